// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Arbiter

This block holds one semaphore token that two independent ports share. They are called the left port and the right port. Each port has a write strobe, a write data bit and a status flag. A port asks for the token by writing 0 and gives it back by writing 1. Its status flag reads 0 while it owns the token and 1 at all other times.

A request that cannot be granted at once is not dropped. It is held as a pending request for that port. When the owner later writes 1, the token goes straight to the waiting port, with no pass through the free state. Ownership and the pending flags are registered. A write therefore shows on the status flags from the clock edge that samples the write onward. Software on either side can use the block as a mutual-exclusion lock for a shared resource. It does not need to poll again after a failed attempt.

Top module: `sema_pair_arbiter`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the semaphore is free, both flags read 1 and no request is pending. This includes a request that was pending before the reset.
- R2: A port that writes 0 while the semaphore is free becomes the owner. Its flag reads 0 and the other flag reads 1.
- R3: If both ports write 0 in the same cycle while the semaphore is free, the left port becomes the owner. The right request is held as pending.
- R4: A port that writes 0 while the other port owns the token changes no flag. The owner keeps the token.
- R5: When the owner writes 1 while the other port has a pending request, the token passes directly to the other port. The releasing flag reads 1 and the new owner's flag reads 0. This holds in both directions, and also when the other port's 0 is written in the same cycle as the release.
- R6: When the owner writes 1 and no request is pending, the semaphore becomes free and both flags read 1.
- R7: A port that writes 1 while it does not own the token clears its own pending request and has no other effect.
- R8: A flag reads 0 only for the port that owns the token, so the two flags are never 0 together.
- R9: An owner that writes 0 again keeps the token and leaves no pending request of its own. Its next write of 1 with nothing pending frees the semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| l_wr_en | input | 1 | Left port write strobe |
| l_wr_bit | input | 1 | Left port write data (0 requests, 1 releases) |
| r_wr_en | input | 1 | Right port write strobe |
| r_wr_bit | input | 1 | Right port write data (0 requests, 1 releases) |
| l_flag | output | 1 | Left status: 0 while the left port owns the token |
| r_flag | output | 1 | Right status: 0 while the right port owns the token |

## Verification
The bench drives simultaneous requests on a free semaphore. A design without a tie-break would grant the token to both ports or to neither, and a design that drops the losing request would free the semaphore instead of handing it to the right port. It also checks a release that arrives in the same cycle as the other port's request, where a design that reads only the latched pending flag would wrongly go free. Further scenarios cover the cancellation of a pending request, a repeated 0 from the owner that must not leave a stale self-request, and a reset while a request is pending, which must not carry a handoff across the reset.

// File: rtl/sema_pkg.sv
// Shared types for the two-port semaphore arbiter.
// Side index 0 is the left port and index 1 is the right port.
package sema_pkg;
    localparam int NUM_SIDES = 2;
    localparam int SIDE_L    = 0;
    localparam int SIDE_R    = 1;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } own_t;
endpackage

// File: rtl/sema_wr_decode.sv
// Turns one port's write strobe and data bit into a request pulse (write 0)
// or a release pulse (write 1). Purely combinational. Assumes the inputs
// are synchronous to the arbiter clock.
module sema_wr_decode (
    input  logic wr_en,
    input  logic wr_bit,
    output logic req,
    output logic rel
);
    // Split the write into request and release.
    always_comb begin
        req = wr_en & ~wr_bit;
        rel = wr_en &  wr_bit;
    end
endmodule

// File: rtl/sema_owner_fsm.sv
// Holds token ownership and one pending-request flag per side. A refused
// request is latched, and a release hands the token directly to a waiting
// side. Left wins a tie on a free semaphore. Assumes that req and rel of
// one side are never high together.
module sema_owner_fsm
    import sema_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SIDES-1:0] req,
    input  logic [NUM_SIDES-1:0] rel,
    output own_t                 own_q,
    output logic [NUM_SIDES-1:0] pend_q
);
    own_t                 own_n;
    logic [NUM_SIDES-1:0] pend_n;

    // Next ownership and pending flags from the current writes.
    always_comb begin
        own_n  = own_q;
        pend_n = (pend_q | req) & ~rel;
        case (own_q)
            OWN_NONE: begin
                if (pend_n[SIDE_L])      own_n = OWN_LEFT;
                else if (pend_n[SIDE_R]) own_n = OWN_RIGHT;
            end
            OWN_LEFT: begin
                if (rel[SIDE_L]) own_n = pend_n[SIDE_R] ? OWN_RIGHT : OWN_NONE;
            end
            OWN_RIGHT: begin
                if (rel[SIDE_R]) own_n = pend_n[SIDE_L] ? OWN_LEFT : OWN_NONE;
            end
            default: own_n = OWN_NONE;
        endcase
        if (own_n == OWN_LEFT)  pend_n[SIDE_L] = 1'b0;
        if (own_n == OWN_RIGHT) pend_n[SIDE_R] = 1'b0;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q  <= OWN_NONE;
            pend_q <= '0;
        end else begin
            own_q  <= own_n;
            pend_q <= pend_n;
        end
    end

    // R1: reset leaves the semaphore free with nothing pending
    a_r1_reset_free: assert property (@(posedge clk)
        !rst_n |=> (own_q == OWN_NONE && pend_q == '0));

    // R2: a left request on a free semaphore is granted
    a_r2_free_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_NONE && req[SIDE_L]) |=> own_q == OWN_LEFT);

    // R3: in a tie the right request is kept
    a_r3_tie_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_NONE && req[SIDE_L] && req[SIDE_R]) |=> pend_q[SIDE_R]);

    // R4: the owner keeps the token until it releases
    a_r4_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_LEFT && !rel[SIDE_L]) |=> own_q == OWN_LEFT);
    a_r4_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_RIGHT && !rel[SIDE_R]) |=> own_q == OWN_RIGHT);

    // R5: a release with the other side waiting hands the token over
    a_r5_handoff_lr: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_LEFT && rel[SIDE_L] && pend_q[SIDE_R]) |=> own_q == OWN_RIGHT);
    a_r5_handoff_rl: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_RIGHT && rel[SIDE_R] && pend_q[SIDE_L]) |=> own_q == OWN_LEFT);

    // R6: a release with nothing waiting frees the semaphore
    a_r6_release_free: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_LEFT && rel[SIDE_L] && !pend_q[SIDE_R] && !req[SIDE_R])
        |=> own_q == OWN_NONE);

    // R7: a non-owner writing 1 drops its own pending request
    a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q != OWN_RIGHT && rel[SIDE_R]) |=> !pend_q[SIDE_R]);

    // R9: the owner never carries a pending request of its own
    a_r9_no_self_pend: assert property (@(posedge clk) disable iff (!rst_n)
        own_q == OWN_LEFT |-> !pend_q[SIDE_L]);
endmodule

// File: rtl/sema_status_drive.sv
// Produces the per-side status flags from ownership. A flag is 0 only for
// the side that owns the token. Assumes the ownership code is one of the
// three legal values.
module sema_status_drive
    import sema_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  own_t                 own_q,
    output logic [NUM_SIDES-1:0] flag
);
    own_t side_code [NUM_SIDES];
    assign side_code[SIDE_L] = OWN_LEFT;
    assign side_code[SIDE_R] = OWN_RIGHT;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_flag
        // Flag is low only while this side holds the token.
        always_comb flag[s] = (own_q != side_code[s]);
    end

    // R8: the two flags are never low together
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        flag != '0);
endmodule

// File: rtl/sema_pair_arbiter.sv
// Top of the two-port semaphore arbiter. It decodes each port's writes,
// keeps ownership and pending requests, and drives the status flags.
// Assumes both ports are synchronous to clk.
module sema_pair_arbiter
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_wr_en,
    input  logic l_wr_bit,
    input  logic r_wr_en,
    input  logic r_wr_bit,
    output logic l_flag,
    output logic r_flag
);
    logic [NUM_SIDES-1:0] wr_en_v, wr_bit_v, req_v, rel_v, pend_v, flag_v;
    own_t                 own_v;

    assign wr_en_v  = {r_wr_en,  l_wr_en};
    assign wr_bit_v = {r_wr_bit, l_wr_bit};

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_dec
        sema_wr_decode u_dec (
            .wr_en  (wr_en_v[s]),
            .wr_bit (wr_bit_v[s]),
            .req    (req_v[s]),
            .rel    (rel_v[s])
        );
    end

    sema_owner_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_v),
        .rel    (rel_v),
        .own_q  (own_v),
        .pend_q (pend_v)
    );

    sema_status_drive u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .own_q (own_v),
        .flag  (flag_v)
    );

    assign l_flag = flag_v[SIDE_L];
    assign r_flag = flag_v[SIDE_R];
endmodule

// File: tb/sema_pair_arbiter_tb_top.sv
module sema_pair_arbiter_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_wr_en = 1'b0, l_wr_bit = 1'b1, r_wr_en = 1'b0, r_wr_bit = 1'b1;
    logic l_flag, r_flag;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    sema_pair_arbiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_wr_en(l_wr_en), .l_wr_bit(l_wr_bit),
        .r_wr_en(r_wr_en), .r_wr_bit(r_wr_bit),
        .l_flag(l_flag), .r_flag(r_flag)
    );

    // One cycle of writes; en/bit per side. Outputs settle after the edge.
    task automatic step(input logic le, input logic lb, input logic re, input logic rb);
        @(negedge clk);
        l_wr_en = le; l_wr_bit = lb; r_wr_en = re; r_wr_bit = rb;
        @(posedge clk);
        #2;
        l_wr_en = 1'b0; r_wr_en = 1'b0;
    endtask

    task automatic check(input string req, input logic el, input logic er);
        total++;
        if (l_flag !== el || r_flag !== er) begin
            bad++;
            $display("FAIL %s: flags l=%b r=%b expected l=%b r=%b", req, l_flag, r_flag, el, er);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2; rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", 1'b1, 1'b1);
    endtask

    task automatic t_free_grant();
        step(1,0,0,0); check("R2", 1'b0, 1'b1);
        step(1,1,0,0); check("R6", 1'b1, 1'b1);
        step(0,0,1,0); check("R2", 1'b1, 1'b0);
        step(0,0,1,1); check("R6", 1'b1, 1'b1);
    endtask

    task automatic t_block_handoff();
        step(1,0,0,0);
        step(0,0,1,0); check("R4", 1'b0, 1'b1);
        step(1,1,0,0); check("R5", 1'b1, 1'b0);
        step(0,0,1,1); check("R6", 1'b1, 1'b1);
        step(0,0,1,0);
        step(1,0,0,0); check("R4", 1'b1, 1'b0);
        step(0,0,1,1); check("R5", 1'b0, 1'b1);
        step(1,1,0,0); check("R6", 1'b1, 1'b1);
    endtask

    task automatic t_tie();
        step(1,0,1,0); check("R3", 1'b0, 1'b1);
        step(1,1,0,0); check("R3", 1'b1, 1'b0);
        step(0,0,1,1); check("R3", 1'b1, 1'b1);
    endtask

    task automatic t_cancel();
        step(1,0,0,0);
        step(0,0,1,0);
        step(0,0,1,1); check("R7", 1'b0, 1'b1);
        step(1,1,0,0); check("R7", 1'b1, 1'b1);
        step(1,1,0,0); check("R7", 1'b1, 1'b1);
    endtask

    task automatic t_owner_rewrite();
        step(1,0,0,0);
        step(1,0,0,0); check("R9", 1'b0, 1'b1);
        step(1,1,0,0); check("R9", 1'b1, 1'b1);
    endtask

    task automatic t_same_cycle();
        step(1,0,0,0);
        step(1,1,1,0); check("R5", 1'b1, 1'b0);
        step(0,0,1,1); check("R8", 1'b1, 1'b1);
    endtask

    task automatic t_reset_pending();
        step(1,0,0,0);
        step(0,0,1,0);
        do_reset(); check("R1", 1'b1, 1'b1);
        step(1,0,0,0);
        step(1,1,0,0); check("R1", 1'b1, 1'b1);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_free_grant();
        t_block_handoff();
        t_tie();
        t_cancel();
        t_owner_rewrite();
        t_same_cycle();
        t_reset_pending();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule